// File: doc/BRIEF.md
# Echo-Readback Serial Register Target

This block is a serial-peripheral-interface target that lets an external host reach an internal register file with 8-bit addresses and 8-bit data. Every transaction is a fixed 17-bit frame sent MSB first. The frame holds a direction flag, an address and a data byte. The host selects the target by pulling its active-low select line low, toggles SCK (idle low) 17 times and releases the select line. A frame takes effect only when it is complete and properly closed.

Replies are delayed by one frame. While a frame shifts in, the output line returns the previous committed frame: its direction flag, its address and the register content captured after that frame took effect. A read therefore needs two frames. The first carries the address. The second is a filler read of address 0xFF, and the wanted byte arrives on the last eight output bits of that second frame.

The serial lines are oversampled by the chip's system clock through synchronisers. The register file sits outside the block behind a plain port: address, write data, a one-cycle write strobe and combinational read data.

Top module: `spi_echo_target`

## Requirements
- R1: A frame is 17 bits, MSB first: bit 16 is the direction flag, bits 15..8 are the address, bits 7..0 are the data. Each MOSI bit is taken on a rising SCK edge while the target is selected.
- R2: A frame commits only when ss_n rises after exactly 17 rising SCK edges. A frame of 16 or 18 clocks causes no write and leaves the echo of the last committed frame unchanged.
- R3: A committed frame whose flag is 0 (write) gives exactly one reg_we pulse of one cycle, with reg_addr equal to the frame address and reg_wdata equal to the frame data.
- R4: A committed frame whose flag is 1 (read) causes no write, and its data bits are ignored whatever their value. The register at its address is captured for the echo.
- R5: During each frame, miso shifts out the previous committed frame's {flag, address, captured data} MSB first. Each bit is stable before the rising SCK edge the host samples it on, and it advances on falling edges.
- R6: The echo of a write frame carries the register value read back after the write has taken effect.
- R7: A filler frame that reads address 0xFF is handled as an ordinary read, so the next frame echoes {1, 0xFF, content of 0xFF}.
- R8: miso_en is high while ss_n is low and goes low within three clock cycles of ss_n going high. While miso_en is low, miso is 0.
- R9: After reset the echo register is zero, so the first frame returns all zeros, and reg_we and miso_en are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_n | input | 1 | Active-low target select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host (pad data) |
| miso_en | output | 1 | Output enable for the miso pad; low means high impedance |
| reg_addr | output | 8 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe, one cycle |
| reg_rdata | input | 8 | Register file read data, combinational from reg_addr |

## Verification
The bound checker watches properties that hold on every cycle. The write strobe is a single cycle and appears only right after a frame commits. A read frame never writes. The register address changes only at a commit. Output enable and data stay low once the select line has been high for a few cycles. Other behaviours need the bench's frame sequences: the one-frame delay of the echo, the value read back after a write, the handling of the 0xFF filler read, and the discarding of 16- and 18-clock frames. These depend on what earlier frames did, so the bench checks them against its own model of the register file.

// File: rtl/spi_echo_pkg.sv
// Package: shared widths and the frame layout for the echo-readback target.
// Assumes 8-bit address and data; the frame length is derived from them.
package spi_echo_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 8;
    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int CNT_W = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/spi_echo_sync.sv
// Synchroniser and edge finder for the three serial inputs.
// Assumes the serial clock is much slower than clk (at least 6 clk per half period).
module spi_echo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n,
    input  logic sck,
    input  logic mosi,
    output logic sel,
    output logic sel_start,
    output logic sel_end,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int NSIG = 3;
    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] chain [STAGES];
    logic [NSIG-1:0] last;

    assign raw = {ss_n, sck, mosi};

    // Synchroniser stages, one per generate step; reset to deselected, clock low.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 3'b100;
                else        chain[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 3'b100;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    // Previous synchronised value, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 3'b100;
        else        last <= chain[STAGES-1];
    end

    assign sel       = ~chain[STAGES-1][2];
    assign sel_start = last[2] & ~chain[STAGES-1][2];
    assign sel_end   = ~last[2] & chain[STAGES-1][2];
    assign sck_rise  = ~last[1] & chain[STAGES-1][1];
    assign sck_fall  = last[1] & ~chain[STAGES-1][1];
    assign mosi_s    = chain[STAGES-1][0];
endmodule

// File: rtl/spi_echo_rx.sv
// Receive side: shifts MOSI in on rising SCK, counts clocks and flags a
// commit when select ends after exactly FRAME_BITS clocks.
module spi_echo_rx
    import spi_echo_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel,
    input  logic   sel_start,
    input  logic   sel_end,
    input  logic   sck_rise,
    input  logic   mosi_s,
    output frame_t frame,
    output logic   commit
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(FRAME_BITS + 1);
    logic [FRAME_BITS-1:0] sr;
    logic [CNT_W-1:0]      cnt;

    // Shift register and saturating clock counter for the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (sel_start) begin
            cnt <= '0;
        end else if (sel && sck_rise) begin
            sr <= {sr[FRAME_BITS-2:0], mosi_s};
            if (cnt != SAT) cnt <= cnt + 1'b1;
        end
    end

    assign frame  = frame_t'(sr);
    assign commit = sel_end && (cnt == FULL);
endmodule

// File: rtl/spi_echo_tx.sv
// Transmit side: loads the echo word at frame start and shifts it out MSB
// first, one bit per falling SCK edge. Output is 0 while deselected.
module spi_echo_tx
    import spi_echo_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  sel_start,
    input  logic                  sck_fall,
    input  logic [FRAME_BITS-1:0] echo,
    output logic                  miso,
    output logic                  miso_en
);
    logic [FRAME_BITS-1:0] sr;

    // Load at select, shift on each falling edge while selected.
    always_ff @(posedge clk) begin
        if (!rst_n)               sr <= '0;
        else if (sel_start)       sr <= echo;
        else if (sel && sck_fall) sr <= {sr[FRAME_BITS-2:0], 1'b0};
    end

    assign miso    = sel & sr[FRAME_BITS-1];
    assign miso_en = sel;
endmodule

// File: rtl/spi_echo_target.sv
// Top: serial register target with one-frame-delayed echo readback.
// Assumes reg_rdata follows reg_addr combinationally and a write lands on
// the clock edge where reg_we is high.
module spi_echo_target
    import spi_echo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic   sel, sel_start, sel_end, sck_rise, sck_fall, mosi_s;
    logic   commit;
    frame_t frame;
    frame_t held;
    logic   wait_wr, capture;
    logic [FRAME_BITS-1:0] echo_q;

    spi_echo_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
        .sel(sel), .sel_start(sel_start), .sel_end(sel_end),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    spi_echo_rx rx_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sel_start(sel_start),
        .sel_end(sel_end), .sck_rise(sck_rise), .mosi_s(mosi_s),
        .frame(frame), .commit(commit)
    );

    // Commit: latch the frame and pulse the write strobe on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= '0;
            reg_we  <= 1'b0;
            wait_wr <= 1'b0;
        end else begin
            reg_we  <= commit & ~frame.rd;
            wait_wr <= commit;
            if (commit) held <= frame;
        end
    end

    // Capture the readback one cycle after the write has landed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capture <= 1'b0;
            echo_q  <= '0;
        end else begin
            capture <= wait_wr;
            if (capture) echo_q <= {held.rd, held.addr, reg_rdata};
        end
    end

    assign reg_addr  = held.addr;
    assign reg_wdata = held.data;

    spi_echo_tx tx_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sel_start(sel_start),
        .sck_fall(sck_fall), .echo(echo_q), .miso(miso), .miso_en(miso_en)
    );
endmodule

// File: rtl/spi_echo_target_chk.sv
// Checker for spi_echo_target, attached with bind. Watches the write strobe,
// the commit path and the idle state of the output.
module spi_echo_target_chk
    import spi_echo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ss_n,
    input logic              miso,
    input logic              miso_en,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              commit,
    input logic              frame_rd
);
    a_r3_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    a_r2_we_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(commit));

    a_r4_read_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_rd) |=> !reg_we);

    a_r2_addr_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> $stable(reg_addr));

    a_r8_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> !miso_en);

    a_r8_zero_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_en |-> !miso);
endmodule

bind spi_echo_target spi_echo_target_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .miso(miso), .miso_en(miso_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .commit(commit), .frame_rd(frame.rd)
);

// File: tb/spi_echo_target_tb_top.sv
// Bench: table of frames with expected echoes, then directed reset,
// select-line and malformed-frame tests.
module spi_echo_target_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_en, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] mem [256];
    int total = 0, bad = 0, we_cnt = 0;
    logic [7:0] last_wa, last_wd;
    logic done = 1'b0;

    always #5 clk = ~clk;

    spi_echo_target dut_i (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_en(miso_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    // Register file model: write on the strobe, combinational read.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt  <= we_cnt + 1;
            last_wa <= reg_addr;
            last_wd <= reg_wdata;
        end
    end
    assign reg_rdata = mem[reg_addr];

    // {frame sent, echo expected}
    localparam logic [33:0] VEC [0:8] = '{
        {17'h0125A, 17'h00000},  // R9 first echo zero; R3 write 12<=5A
        {17'h034C3, 17'h0125A},  // R6 readback after write
        {17'h112FF, 17'h034C3},  // R4 read 12
        {17'h134FF, 17'h1125A},  // R5 echo of read
        {17'h1FFFF, 17'h134C3},  // R7 filler read returns 34 data
        {17'h0FF81, 17'h1FF00},  // R7 filler echoed as read of FF
        {17'h1FFFF, 17'h0FF81},
        {17'h155FF, 17'h1FF81},
        {17'h1FFFF, 17'h15500}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nclk SCK cycles; returns the first 17 MISO bits seen.
    task automatic frame(input logic [16:0] bits, input int nclk, output logic [16:0] got);
        got = '0;
        ss_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 17) ? bits[16-i] : 1'b1;
            wait_clk(8);
            if (i < 17) got = {got[15:0], miso};
            sck = 1'b1;
            wait_clk(8);
            sck = 1'b0;
        end
        wait_clk(8);
        ss_n = 1'b1;
        wait_clk(12);
    endtask

    initial begin
        logic [16:0] got;
        wait_clk(4);
        check("R9 miso_en after reset", 32'(miso_en), 0);
        check("R9 reg_we after reset", 32'(reg_we), 0);
        rst_n = 1'b1;
        wait_clk(4);
        ss_n = 1'b0;
        wait_clk(6);
        check("R8 miso_en while selected", 32'(miso_en), 1);
        ss_n = 1'b1;
        wait_clk(6);
        check("R8 miso_en after release", 32'(miso_en), 0);
        check("R8 miso zero when disabled", 32'(miso), 0);
        wait_clk(6);

        for (int k = 0; k < 9; k++) begin
            frame(VEC[k][33:17], 17, got);
            check($sformatf("R5 echo frame %0d", k), 32'(got), 32'(VEC[k][16:0]));
            if (k == 0) begin
                check("R3 write address", 32'(last_wa), 32'h12);
                check("R3 write data", 32'(last_wd), 32'h5A);
                check("R1 mem 12 written", 32'(mem[8'h12]), 32'h5A);
            end
        end
        check("R3 one strobe per write", 32'(we_cnt), 3);

        // Short frame: discarded (R2).
        frame(17'h01200, 16, got);
        frame(17'h112FF, 17, got);
        check("R2 echo unchanged after short frame", 32'(got), 32'h1FF81);
        frame(17'h1FFFF, 17, got);
        check("R2 short frame did not write", 32'(got), 32'h1125A);

        // Long frame: discarded (R2).
        frame(17'h03400, 18, got);
        frame(17'h134FF, 17, got);
        check("R2 echo unchanged after long frame", 32'(got), 32'h1FF81);
        frame(17'h1FFFF, 17, got);
        check("R2 long frame did not write", 32'(got), 32'h134C3);
        check("R2 no strobe from bad frames", 32'(we_cnt), 3);

        // Read with non-ones data bits: data ignored (R4).
        frame(17'h13400, 17, got);
        frame(17'h1FFFF, 17, got);
        check("R4 read with zero data echoes content", 32'(got), 32'h134C3);
        check("R4 read caused no write", 32'(we_cnt), 3);
        check("R4 mem 34 intact", 32'(mem[8'h34]), 32'hC3);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule